// File: doc/BRIEF.md
# Toggle-Strobe Parallel Command Slave

This block is the logic-side end of a parallel link from a host microcontroller. The host sets a 4-bit opcode and an 8-bit parameter byte. It then flips a single write-strobe line. Either a rising or a falling transition of that line announces one new transfer. A 16-bit data word travels with each transfer. The block takes each transfer it accepts and turns it into a one-cycle command pulse for internal logic. The pulse carries the opcode, the parameter and the data word.

A few opcodes are handled inside the block. All-ones is the idle opcode and does nothing. One opcode sets or clears a bypass-enable flag. One opcode returns a fixed version word. One opcode starts a multi-word read. During a read, the block presents one word at a time on the data bus and raises its ready line for each word. The host asks for the next word with a short high-then-low pulse on the direction line. Bus ownership follows that direction line: the block drives the data bus only while the line is low. Strobe, direction and opcode come from an asynchronous host and are synchronized first. The opcode, parameter and data word are sampled one clock after the strobe edge is seen.

Top module: `tsp_cmd_slave`

## Requirements
- R1: After synchronous reset, host_ready stays low for exactly INIT_CYCLES clock cycles and then rises. bypass_en is 0 after reset.
- R2: Each transition of host_wtrig, rising or falling, that carries an ordinary opcode gives exactly one one-cycle cmd_valid pulse. The pulse carries cmd_op, cmd_par and cmd_word equal to host_cmd, host_par and host_data_in at the time of the transition. The opcodes handled inside the block are 4'h1, 4'h2, 4'h3 and 4'hF; every other value is ordinary.
- R3: Opcode 4'hF is a no-operation. It gives no cmd_valid and leaves bypass_en unchanged.
- R4: host_ready is low in the cycle before each cmd_valid pulse. In a burst, the opcode and parameter stay fixed and the strobe toggles once per word, at least 6 cycles apart, without the host waiting for ready. Every word of such a burst is delivered, in order.
- R5: host_data_oe is high exactly when host_dir is low.
- R6: Opcode 4'h2 copies host_par bit 0 into bypass_en (1 enables, 0 disables) and gives no cmd_valid.
- R7: Opcode 4'h1 makes host_data_out equal VERSION_WORD with host_ready high. This lasts until host_cmd is 0 and host_par is 0, with no strobe needed. host_data_out then returns to 0 and no cmd_valid is given.
- R8: Opcode 4'h3 with host_par = N > 0 presents rd_data for rd_index = 0, 1, …, N-1, one word at a time, with host_ready high while a word is valid. A high-then-low pulse on host_dir drops host_ready and advances rd_index by one. A rise of host_dir while the last word is shown ends the read with host_ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| host_cmd | input | 4 | Opcode from host (asynchronous) |
| host_par | input | 8 | Parameter byte from host |
| host_wtrig | input | 1 | Toggling write strobe from host (asynchronous) |
| host_dir | input | 1 | Bus direction from host: low means the block drives |
| host_data_in | input | 16 | Data bus as seen from the pad, host to block |
| host_data_out | output | 16 | Data bus value driven toward host |
| host_data_oe | output | 1 | Output enable for the data bus pads |
| host_ready | output | 1 | Ready for a transfer / read word valid |
| bypass_en | output | 1 | Bypass-enable flag |
| cmd_valid | output | 1 | One-cycle pulse per delivered command |
| cmd_op | output | 4 | Opcode of the delivered command |
| cmd_par | output | 8 | Parameter of the delivered command |
| cmd_word | output | 16 | Data word of the delivered command |
| rd_index | output | 8 | Index of the word being read |
| rd_data | input | 16 | Read word supplied by internal logic for rd_index |

## Verification
The assertions assume the host follows the link's pacing. Strobe edges are at least 6 cycles apart. The opcode, parameter and data word are stable from the strobe edge until the command has been taken. Each direction pulse lasts at least 2 cycles. rd_data follows rd_index within one cycle. The stimulus meets all of this: it changes inputs only between clock edges, waits 6 to 10 cycles after each strobe toggle, holds every direction pulse for 2 cycles, and computes rd_data combinationally from rd_index.

// File: rtl/tsp_pkg.sv
package tsp_pkg;

    parameter int CMD_W  = 4;
    parameter int PAR_W  = 8;
    parameter int DATA_W = 16;

    localparam logic [CMD_W-1:0] OP_VERSION = CMD_W'(1);
    localparam logic [CMD_W-1:0] OP_BYPASS  = CMD_W'(2);
    localparam logic [CMD_W-1:0] OP_READ    = CMD_W'(3);
    localparam logic [CMD_W-1:0] OP_IDLE    = {CMD_W{1'b1}};

    typedef enum logic [2:0] {
        ST_INIT,
        ST_IDLE,
        ST_SAMPLE,
        ST_VER,
        ST_RWAIT,
        ST_RVALID,
        ST_RPULSE
    } ctrl_state_t;

    typedef struct packed {
        logic [CMD_W-1:0]  op;
        logic [PAR_W-1:0]  par;
        logic [DATA_W-1:0] word;
    } xfer_t;

    function automatic logic is_local_op(input logic [CMD_W-1:0] op);
        return (op == OP_VERSION) || (op == OP_BYPASS) ||
               (op == OP_READ)    || (op == OP_IDLE);
    endfunction

    function automatic logic ready_in(input ctrl_state_t st);
        return (st == ST_IDLE) || (st == ST_VER) || (st == ST_RVALID);
    endfunction

endpackage

// File: rtl/tsp_sync.sv
module tsp_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stg[gi] <= RST_VAL;
                end else begin
                    if (gi == 0) stg[gi] <= d;
                    else         stg[gi] <= stg[(gi == 0) ? 0 : gi-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/tsp_edge.sv
module tsp_edge #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic rise,
    output logic fall
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= RST_VAL;
        else     prev <= d;
    end

    assign rise = d & ~prev;
    assign fall = ~d & prev;
endmodule

// File: rtl/tsp_ctrl.sv
module tsp_ctrl
    import tsp_pkg::*;
#(
    parameter int                INIT_CYCLES  = 16,
    parameter logic [DATA_W-1:0] VERSION_WORD = 16'h2A51
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wt_edge,
    input  logic              dir_rise,
    input  logic              dir_fall,
    input  logic [CMD_W-1:0]  cmd_sync,
    input  logic [CMD_W-1:0]  host_cmd,
    input  logic [PAR_W-1:0]  host_par,
    input  logic [DATA_W-1:0] host_din,
    input  logic [DATA_W-1:0] rd_data,
    output logic              ready,
    output logic              bypass,
    output logic              cmd_valid,
    output xfer_t             xfer,
    output logic [PAR_W-1:0]  rd_index,
    output logic [DATA_W-1:0] dout
);
    localparam int CNT_W = $clog2(INIT_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(INIT_CYCLES - 1);

    ctrl_state_t      state;
    logic [CNT_W-1:0] init_cnt;
    logic [PAR_W-1:0] rd_left;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_INIT;
            init_cnt  <= '0;
            bypass    <= 1'b0;
            cmd_valid <= 1'b0;
            xfer      <= '0;
            rd_left   <= '0;
            rd_index  <= '0;
        end else begin
            cmd_valid <= 1'b0;
            unique case (state)
                ST_INIT: begin
                    if (init_cnt == CNT_LAST) state <= ST_IDLE;
                    else                      init_cnt <= init_cnt + 1'b1;
                end
                ST_IDLE: begin
                    if (wt_edge) state <= ST_SAMPLE;
                end
                ST_SAMPLE: begin
                    state <= ST_IDLE;
                    if (host_cmd == OP_BYPASS) begin
                        bypass <= host_par[0];
                    end else if (host_cmd == OP_VERSION) begin
                        state <= ST_VER;
                    end else if (host_cmd == OP_READ) begin
                        if (host_par != '0) begin
                            rd_left  <= host_par;
                            rd_index <= '0;
                            state    <= ST_RWAIT;
                        end
                    end else if (!is_local_op(host_cmd)) begin
                        cmd_valid <= 1'b1;
                        xfer      <= '{op: host_cmd, par: host_par, word: host_din};
                    end
                end
                ST_VER: begin
                    if (cmd_sync == '0 && host_par == '0) state <= ST_IDLE;
                end
                ST_RWAIT: begin
                    state <= ST_RVALID;
                end
                ST_RVALID: begin
                    if (dir_rise) begin
                        if (rd_left == PAR_W'(1)) begin
                            rd_left <= '0;
                            state   <= ST_IDLE;
                        end else begin
                            state <= ST_RPULSE;
                        end
                    end
                end
                ST_RPULSE: begin
                    if (dir_fall) begin
                        rd_left  <= rd_left - 1'b1;
                        rd_index <= rd_index + 1'b1;
                        state    <= ST_RWAIT;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign ready = ready_in(state);

    always_comb begin
        unique case (state)
            ST_VER:    dout = VERSION_WORD;
            ST_RVALID: dout = rd_data;
            default:   dout = '0;
        endcase
    end
endmodule

// File: rtl/tsp_cmd_slave.sv
module tsp_cmd_slave
    import tsp_pkg::*;
#(
    parameter int                INIT_CYCLES  = 16,
    parameter int                SYNC_STAGES  = 2,
    parameter logic [DATA_W-1:0] VERSION_WORD = 16'h2A51
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CMD_W-1:0]  host_cmd,
    input  logic [PAR_W-1:0]  host_par,
    input  logic              host_wtrig,
    input  logic              host_dir,
    input  logic [DATA_W-1:0] host_data_in,
    output logic [DATA_W-1:0] host_data_out,
    output logic              host_data_oe,
    output logic              host_ready,
    output logic              bypass_en,
    output logic              cmd_valid,
    output logic [CMD_W-1:0]  cmd_op,
    output logic [PAR_W-1:0]  cmd_par,
    output logic [DATA_W-1:0] cmd_word,
    output logic [PAR_W-1:0]  rd_index,
    input  logic [DATA_W-1:0] rd_data
);
    localparam int SW = CMD_W + 2;
    localparam logic [SW-1:0] SYNC_RST = {OP_IDLE, 1'b1, 1'b0};

    logic [SW-1:0] sync_bus;
    logic          wt_rise, wt_fall, dir_rise, dir_fall;
    xfer_t         xfer;

    tsp_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({host_cmd, host_dir, host_wtrig}),
        .q   (sync_bus)
    );

    tsp_edge #(.RST_VAL(1'b0)) u_wt_edge (
        .clk (clk), .rst (rst), .d (sync_bus[0]),
        .rise (wt_rise), .fall (wt_fall)
    );

    tsp_edge #(.RST_VAL(1'b1)) u_dir_edge (
        .clk (clk), .rst (rst), .d (sync_bus[1]),
        .rise (dir_rise), .fall (dir_fall)
    );

    tsp_ctrl #(.INIT_CYCLES(INIT_CYCLES), .VERSION_WORD(VERSION_WORD)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wt_edge   (wt_rise | wt_fall),
        .dir_rise  (dir_rise),
        .dir_fall  (dir_fall),
        .cmd_sync  (sync_bus[SW-1:2]),
        .host_cmd  (host_cmd),
        .host_par  (host_par),
        .host_din  (host_data_in),
        .rd_data   (rd_data),
        .ready     (host_ready),
        .bypass    (bypass_en),
        .cmd_valid (cmd_valid),
        .xfer      (xfer),
        .rd_index  (rd_index),
        .dout      (host_data_out)
    );

    assign host_data_oe = ~host_dir;
    assign cmd_op       = xfer.op;
    assign cmd_par      = xfer.par;
    assign cmd_word     = xfer.word;
endmodule

// File: rtl/tsp_cmd_slave_chk.sv
module tsp_cmd_slave_chk
    import tsp_pkg::*;
#(
    parameter int INIT_CYCLES = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             host_ready,
    input logic             bypass_en,
    input logic             cmd_valid,
    input logic [CMD_W-1:0] cmd_op,
    input logic [PAR_W-1:0] rd_index
);
    localparam int CW = $clog2(INIT_CYCLES + 1);
    logic [CW-1:0] cyc;

    always_ff @(posedge clk) begin
        if (rst)                          cyc <= '0;
        else if (cyc != CW'(INIT_CYCLES)) cyc <= cyc + 1'b1;
    end

    a_r1_init_not_ready: assert property (@(posedge clk) disable iff (rst)
        (cyc < CW'(INIT_CYCLES)) |-> !host_ready);

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    a_r3_no_local_out: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> !is_local_op(cmd_op));

    a_r4_busy_before_valid: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> !$past(host_ready));

    a_r6_bypass_when_busy: assert property (@(posedge clk) disable iff (rst)
        (bypass_en != $past(bypass_en)) |-> !$past(host_ready));

    a_r8_index_step: assert property (@(posedge clk) disable iff (rst)
        (rd_index != $past(rd_index)) |->
            (rd_index == $past(rd_index) + 1'b1) || (rd_index == '0));
endmodule

bind tsp_cmd_slave tsp_cmd_slave_chk #(.INIT_CYCLES(INIT_CYCLES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_ready (host_ready),
    .bypass_en  (bypass_en),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .rd_index   (rd_index)
);

// File: tb/test_tsp_cmd_slave.sv
`timescale 1ns/1ps
module test_tsp_cmd_slave;

    localparam int INIT = 16;
    localparam logic [15:0] VER = 16'h2A51;

    typedef struct packed {
        logic [3:0]  c;
        logic [7:0]  p;
        logic [15:0] w;
        logic        v;
        logic        b;
    } vec_t;

    localparam vec_t VEC [0:6] = '{
        '{4'h4, 8'h11, 16'h1234, 1'b1, 1'b0},
        '{4'hF, 8'h22, 16'hFFFF, 1'b0, 1'b0},
        '{4'h2, 8'h01, 16'h0000, 1'b0, 1'b1},
        '{4'h0, 8'h00, 16'hBEEF, 1'b1, 1'b1},
        '{4'hE, 8'hFE, 16'h0001, 1'b1, 1'b1},
        '{4'h2, 8'h00, 16'h0000, 1'b0, 1'b0},
        '{4'h7, 8'h80, 16'h8000, 1'b1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  host_cmd = 4'hF;
    logic [7:0]  host_par = 8'h00;
    logic        host_wtrig = 1'b0;
    logic        host_dir = 1'b1;
    logic [15:0] host_data_in = 16'h0;
    logic [15:0] host_data_out;
    logic        host_data_oe, host_ready, bypass_en, cmd_valid;
    logic [3:0]  cmd_op;
    logic [7:0]  cmd_par;
    logic [15:0] cmd_word;
    logic [7:0]  rd_index;
    logic [15:0] rd_data;

    int checks = 0;
    int errors = 0;
    int vcount = 0;
    logic [15:0] seen_word [0:63];

    always #2 clk = ~clk;

    assign rd_data = 16'hA000 | {8'h00, rd_index};

    tsp_cmd_slave i_tsp_cmd_slave (
        .clk (clk), .rst (rst),
        .host_cmd (host_cmd), .host_par (host_par),
        .host_wtrig (host_wtrig), .host_dir (host_dir),
        .host_data_in (host_data_in), .host_data_out (host_data_out),
        .host_data_oe (host_data_oe), .host_ready (host_ready),
        .bypass_en (bypass_en), .cmd_valid (cmd_valid),
        .cmd_op (cmd_op), .cmd_par (cmd_par), .cmd_word (cmd_word),
        .rd_index (rd_index), .rd_data (rd_data)
    );

    always @(negedge clk) begin
        if (!rst && cmd_valid) begin
            seen_word[vcount[5:0]] = cmd_word;
            vcount = vcount + 1;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int base;
        int n;
        // R1 reset state and init window
        step(3);
        check("R1 ready in reset", host_ready, 0);
        check("R1 bypass in reset", bypass_en, 0);
        rst = 1'b0;
        n = 0;
        while (!host_ready && n < 100) begin
            n++;
            step(1);
        end
        check("R1 init length", n, INIT);

        // R5 bus ownership follows direction
        check("R5 oe with dir high", host_data_oe, 0);
        host_dir = 1'b0; #1;
        check("R5 oe with dir low", host_data_oe, 1);
        host_dir = 1'b1; #1;

        // Table walk: R2 R3 R6, both strobe edge polarities
        for (int i = 0; i <= 6; i++) begin
            base = vcount;
            host_cmd = VEC[i].c;
            host_par = VEC[i].p;
            host_data_in = VEC[i].w;
            host_wtrig = ~host_wtrig;
            step(10);
            check("R2/R3 pulse count", vcount - base, {31'd0, VEC[i].v});
            if (VEC[i].v) begin
                check("R2 op", cmd_op, VEC[i].c);
                check("R2 par", cmd_par, VEC[i].p);
                check("R2 word", cmd_word, VEC[i].w);
            end
            check("R6/R3 bypass", bypass_en, VEC[i].b);
            check("R4 ready back", host_ready, 1);
        end

        // R4 burst without waiting for ready
        base = vcount;
        host_cmd = 4'h5;
        host_par = 8'h33;
        for (int k = 0; k < 4; k++) begin
            host_data_in = 16'h5100 + 16'(k);
            host_wtrig = ~host_wtrig;
            step(6);
        end
        step(6);
        check("R4 burst count", vcount - base, 4);
        for (int k = 0; k < 4; k++)
            check("R4 burst word", seen_word[(base + k) % 64], 16'h5100 + 16'(k));

        // R8 multi-word read
        base = vcount;
        host_cmd = 4'h3;
        host_par = 8'd3;
        host_wtrig = ~host_wtrig;
        step(10);
        host_dir = 1'b0;
        step(4);
        check("R8 first word", host_data_out, 16'hA000);
        check("R8 first ready", host_ready, 1);
        check("R8 first index", rd_index, 0);
        for (int k = 1; k < 3; k++) begin
            host_dir = 1'b1;
            step(2);
            host_dir = 1'b0;
            step(1);
            check("R8 ready low in pulse", host_ready, 0);
            step(6);
            check("R8 next word", host_data_out, 16'hA000 + 16'(k));
            check("R8 next ready", host_ready, 1);
        end
        host_dir = 1'b1;
        step(6);
        check("R8 end ready", host_ready, 1);
        check("R8 end bus", host_data_out, 0);
        check("R8 no pulse", vcount - base, 0);

        // R7 version query
        base = vcount;
        host_cmd = 4'h1;
        host_par = 8'h00;
        host_wtrig = ~host_wtrig;
        step(10);
        host_dir = 1'b0;
        step(2);
        check("R7 version word", host_data_out, VER);
        check("R7 version ready", host_ready, 1);
        host_cmd = 4'h0;
        step(6);
        check("R7 version ended", host_data_out, 0);
        check("R7 no pulse", vcount - base, 0);
        host_dir = 1'b1;

        // R1 reset clears bypass
        host_cmd = 4'h2;
        host_par = 8'h01;
        host_wtrig = ~host_wtrig;
        step(10);
        check("R6 bypass set", bypass_en, 1);
        rst = 1'b1;
        step(2);
        check("R1 bypass cleared", bypass_en, 0);
        check("R1 ready low", host_ready, 0);
        rst = 1'b0;
        step(INIT + 2);
        check("R1 ready after init", host_ready, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule